// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block is the combinational hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It reads the register indices and control bits held in the four inter-stage pipeline registers. From them it produces a two-bit bypass select for each of the two ALU operands, and a stall that freezes the program counter and the fetch/decode register while a bubble goes into the decode/execute register.

A parameter picks the build variant. With forwarding on, results held in the execute/memory and memory/writeback registers are routed back to the ALU inputs. The newer of the two wins, and the only stall left is the load-use case. With forwarding off, every select stays at the register-file value. Any read-after-write match against the instruction in execute or memory then stalls decode instead. The register file, the ALU, the operand multiplexers and branch handling sit outside this block.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select uses the encoding 0 = register-file value, 1 = memory/writeback result, 2 = execute/memory result. The value 3 never appears.
- R2: In forwarding mode, operand A select is 2 when the execute/memory register writes a nonzero destination equal to the first source index held in decode/execute (`exRs1`).
- R3: In forwarding mode, operand A select is 1 when the memory/writeback register writes a nonzero destination equal to `exRs1` and the R2 condition does not hold. Otherwise it is 0.
- R4: Operand B select follows the R2/R3 rules against the second source index `exRs2`.
- R5: When both later stages could supply the same operand, the execute/memory result (select 2) takes priority.
- R6: Register index 0 never causes forwarding or a stall, whatever the write and read bits say.
- R7: A load-use stall is raised in both modes when `exMemRead` is set and `exRd` is nonzero and equal to a decode-stage source whose use bit is set.
- R8: `pcHold`, `ifIdHold` and `idExBubble` are all high exactly when `stall` is high, and all low otherwise.
- R9: In stall-only mode (`FORWARD_EN` = 0), both selects are always 0. `stall` is raised when a used decode source equals a nonzero destination that the execute-stage or memory-stage instruction writes.
- R10: In forwarding mode, a read-after-write match that involves no load never raises `stall`.
- R11: A decode source whose use bit is low never contributes to any stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| idRs1 | input | 5 | First source index of the instruction in decode |
| idRs2 | input | 5 | Second source index of the instruction in decode |
| idRs1Used | input | 1 | Decode instruction reads its first source |
| idRs2Used | input | 1 | Decode instruction reads its second source |
| exRs1 | input | 5 | First source index held in decode/execute |
| exRs2 | input | 5 | Second source index held in decode/execute |
| exRd | input | 5 | Destination index held in decode/execute |
| exRegWrite | input | 1 | Execute-stage instruction writes a register |
| exMemRead | input | 1 | Execute-stage instruction is a load |
| memRd | input | 5 | Destination index held in execute/memory |
| memRegWrite | input | 1 | Execute/memory instruction writes a register |
| wbRd | input | 5 | Destination index held in memory/writeback |
| wbRegWrite | input | 1 | Memory/writeback instruction writes a register |
| fwdSelA | output | 2 | Bypass select for ALU operand A |
| fwdSelB | output | 2 | Bypass select for ALU operand B |
| stall | output | 1 | Decode must wait this cycle |
| pcHold | output | 1 | Hold the program counter |
| ifIdHold | output | 1 | Hold the fetch/decode register |
| idExBubble | output | 1 | Clear the control bits entering decode/execute |

## Verification
The bench builds two copies side by side on the same stimulus: one with `FORWARD_EN` = 1 and one with `FORWARD_EN` = 0. The forwarding copy exposes the select priority and the load-use stall. The stall-only copy exposes the execute and memory read-after-write stalls that forwarding hides. Comparing both on every vector shows which stalls are mode-dependent and which, like load-use, must appear in both. A sweep over all 32 indices confirms that index 0 alone stays silent.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int NUM_OPND = 2;
  localparam int SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'd0,
    SEL_WB  = 2'd1,
    SEL_MEM = 2'd2
  } fwd_sel_e;

  // Match strobes passed from the comparator datapath to the control
  typedef struct packed {
    logic [NUM_OPND-1:0] memHit;     // execute/memory dest equals exec-stage source
    logic [NUM_OPND-1:0] wbHit;      // memory/writeback dest equals exec-stage source
    logic [NUM_OPND-1:0] exRawHit;   // exec-stage dest equals used decode source
    logic [NUM_OPND-1:0] memRawHit;  // memory-stage dest equals used decode source
    logic [NUM_OPND-1:0] loadHit;    // exec-stage load dest equals used decode source
  } hit_strobe_t;

endpackage

// File: rtl/hzd_match_dp.sv
module hzd_match_dp
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_OPND-1:0][REG_W-1:0] idSrc,
  input  logic [NUM_OPND-1:0]            idUsed,
  input  logic [NUM_OPND-1:0][REG_W-1:0] exSrc,
  input  logic [REG_W-1:0]               exRd,
  input  logic                           exRegWrite,
  input  logic                           exMemRead,
  input  logic [REG_W-1:0]               memRd,
  input  logic                           memRegWrite,
  input  logic [REG_W-1:0]               wbRd,
  input  logic                           wbRegWrite,
  output hit_strobe_t                    hits
);

  localparam logic [REG_W-1:0] ZERO_IDX = '0;

  logic exWrNz, exLdNz, memWrNz, wbWrNz;

  // Destination qualifiers: a write to index 0 is never a real producer
  assign exWrNz  = exRegWrite  && (exRd  != ZERO_IDX);
  assign exLdNz  = exMemRead   && (exRd  != ZERO_IDX);
  assign memWrNz = memRegWrite && (memRd != ZERO_IDX);
  assign wbWrNz  = wbRegWrite  && (wbRd  != ZERO_IDX);

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    logic idExEq, idMemEq, exMemEq, exWbEq;
    assign idExEq  = (idSrc[g] == exRd);
    assign idMemEq = (idSrc[g] == memRd);
    assign exMemEq = (exSrc[g] == memRd);
    assign exWbEq  = (exSrc[g] == wbRd);

    assign hits.memHit[g]    = memWrNz && exMemEq;
    assign hits.wbHit[g]     = wbWrNz  && exWbEq;
    assign hits.exRawHit[g]  = idUsed[g] && exWrNz  && idExEq;
    assign hits.memRawHit[g] = idUsed[g] && memWrNz && idMemEq;
    assign hits.loadHit[g]   = idUsed[g] && exLdNz  && idExEq;
  end

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter bit FORWARD_EN = 1'b1
) (
  input  hit_strobe_t                    hits,
  output logic [NUM_OPND-1:0][SEL_W-1:0] fwdSel,
  output logic                           stall,
  output logic                           pcHold,
  output logic                           ifIdHold,
  output logic                           idExBubble
);

  logic loadStall;
  logic rawStall;
  logic rawAny;

  assign loadStall = |hits.loadHit;
  assign rawAny    = |(hits.exRawHit | hits.memRawHit);

  if (FORWARD_EN) begin : g_fwd
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_sel
      fwd_sel_e sel;
      always_comb begin
        if (hits.memHit[g])     sel = SEL_MEM;  // newest result first
        else if (hits.wbHit[g]) sel = SEL_WB;
        else                    sel = SEL_RF;
      end
      assign fwdSel[g] = sel;
    end
    assign rawStall = 1'b0;
  end else begin : g_nofwd
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_sel
      assign fwdSel[g] = SEL_RF;
    end
    assign rawStall = rawAny;
  end

  assign stall      = loadStall | rawStall;
  assign pcHold     = stall;
  assign ifIdHold   = stall;
  assign idExBubble = stall;

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzd_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter bit FORWARD_EN = 1'b1
) (
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idRs1Used,
  input  logic             idRs2Used,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exRegWrite,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             stall,
  output logic             pcHold,
  output logic             ifIdHold,
  output logic             idExBubble
);

  logic [NUM_OPND-1:0][REG_W-1:0] idSrc;
  logic [NUM_OPND-1:0][REG_W-1:0] exSrc;
  logic [NUM_OPND-1:0]            idUsed;
  logic [NUM_OPND-1:0][SEL_W-1:0] selVec;
  hit_strobe_t                    hits;

  assign idSrc  = {idRs2, idRs1};
  assign exSrc  = {exRs2, exRs1};
  assign idUsed = {idRs2Used, idRs1Used};

  hzd_match_dp #(.REG_W(REG_W)) dp_i (
    .idSrc       (idSrc),
    .idUsed      (idUsed),
    .exSrc       (exSrc),
    .exRd        (exRd),
    .exRegWrite  (exRegWrite),
    .exMemRead   (exMemRead),
    .memRd       (memRd),
    .memRegWrite (memRegWrite),
    .wbRd        (wbRd),
    .wbRegWrite  (wbRegWrite),
    .hits        (hits)
  );

  hzd_ctrl #(.FORWARD_EN(FORWARD_EN)) ctrl_i (
    .hits       (hits),
    .fwdSel     (selVec),
    .stall      (stall),
    .pcHold     (pcHold),
    .ifIdHold   (ifIdHold),
    .idExBubble (idExBubble)
  );

  assign fwdSelA = selVec[0];
  assign fwdSelB = selVec[1];

endmodule

// File: rtl/hazard_fwd_chk.sv
module hazard_fwd_chk #(
  parameter int REG_W      = 5,
  parameter bit FORWARD_EN = 1'b1
) (
  input logic [REG_W-1:0] idRs1,
  input logic [REG_W-1:0] idRs2,
  input logic             idRs1Used,
  input logic             idRs2Used,
  input logic [REG_W-1:0] exRs1,
  input logic [REG_W-1:0] exRs2,
  input logic [REG_W-1:0] exRd,
  input logic             exMemRead,
  input logic [REG_W-1:0] memRd,
  input logic             memRegWrite,
  input logic [REG_W-1:0] wbRd,
  input logic             wbRegWrite,
  input logic [1:0]       fwdSelA,
  input logic [1:0]       fwdSelB,
  input logic             stall
);

  logic memFeedsA, memFeedsB, loadUse;

  assign memFeedsA = memRegWrite && (memRd != '0) && (memRd == exRs1);
  assign memFeedsB = memRegWrite && (memRd != '0) && (memRd == exRs2);
  assign loadUse   = exMemRead && (exRd != '0) &&
                     ((idRs1Used && idRs1 == exRd) || (idRs2Used && idRs2 == exRd));

  always_comb begin
    AST_SEL_LEGAL: assert (fwdSelA != 2'd3 && fwdSelB != 2'd3); // R1
    AST_MEM_FEEDS_B: assert (!(FORWARD_EN && memFeedsB) || fwdSelB == 2'd2); // R4
    AST_MEM_WINS_A: assert (!(FORWARD_EN && memFeedsA) || fwdSelA == 2'd2); // R5
    AST_WB_SEL_SOURCE: assert (fwdSelA != 2'd1 || (wbRegWrite && wbRd != '0 && wbRd == exRs1 && !memFeedsA)); // R3
    AST_ZERO_NO_FWD: assert ((exRs1 != '0 || fwdSelA == 2'd0) && (exRs2 != '0 || fwdSelB == 2'd0)); // R6
    AST_LOAD_USE_STALL: assert (!loadUse || stall); // R7
    AST_NOFWD_RF_ONLY: assert (FORWARD_EN || (fwdSelA == 2'd0 && fwdSelB == 2'd0)); // R9
  end

endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.REG_W(REG_W), .FORWARD_EN(FORWARD_EN)) chk_i (
  .idRs1       (idRs1),
  .idRs2       (idRs2),
  .idRs1Used   (idRs1Used),
  .idRs2Used   (idRs2Used),
  .exRs1       (exRs1),
  .exRs2       (exRs2),
  .exRd        (exRd),
  .exMemRead   (exMemRead),
  .memRd       (memRd),
  .memRegWrite (memRegWrite),
  .wbRd        (wbRd),
  .wbRegWrite  (wbRegWrite),
  .fwdSelA     (fwdSelA),
  .fwdSelB     (fwdSelB),
  .stall       (stall)
);

// File: tb/hazard_fwd_unit_tb_top.sv
module hazard_fwd_unit_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [4:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic idRs1Used, idRs2Used, exRegWrite, exMemRead, memRegWrite, wbRegWrite;

  logic [1:0] fSelA, fSelB, nSelA, nSelB;
  logic fStall, fPc, fIfId, fBub, nStall, nPc, nIfId, nBub;

  hazard_fwd_unit #(.REG_W(5), .FORWARD_EN(1'b1)) dut_i (
    .idRs1(idRs1), .idRs2(idRs2), .idRs1Used(idRs1Used), .idRs2Used(idRs2Used),
    .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd), .exRegWrite(exRegWrite),
    .exMemRead(exMemRead), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .fwdSelA(fSelA), .fwdSelB(fSelB), .stall(fStall),
    .pcHold(fPc), .ifIdHold(fIfId), .idExBubble(fBub)
  );

  hazard_fwd_unit #(.REG_W(5), .FORWARD_EN(1'b0)) dutNf_i (
    .idRs1(idRs1), .idRs2(idRs2), .idRs1Used(idRs1Used), .idRs2Used(idRs2Used),
    .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd), .exRegWrite(exRegWrite),
    .exMemRead(exMemRead), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .fwdSelA(nSelA), .fwdSelB(nSelB), .stall(nStall),
    .pcHold(nPc), .ifIdHold(nIfId), .idExBubble(nBub)
  );

  typedef struct packed {
    logic [4:0] iA, iB; logic uA, uB;
    logic [4:0] xA, xB, xRd; logic xW, xMr;
    logic [4:0] mRd; logic mW;
    logic [4:0] wRd; logic wW;
    logic [1:0] eA, eB; logic eSF, eSN;
  } vec_t;

  localparam int NVEC = 14;
  // iA iB uA uB | xA xB xRd xW xMr | mRd mW | wRd wW | eA eB eStallFwd eStallNoFwd
  localparam vec_t VECS [NVEC] = '{
    '{5'd0,  5'd0,  1'b0,1'b0, 5'd0,  5'd0,  5'd0,  1'b0,1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0,2'd0, 1'b0,1'b0},
    '{5'd7,  5'd8,  1'b1,1'b1, 5'd3,  5'd0,  5'd9,  1'b1,1'b0, 5'd3,  1'b1, 5'd0,  1'b0, 2'd2,2'd0, 1'b0,1'b0},
    '{5'd10, 5'd11, 1'b1,1'b1, 5'd5,  5'd4,  5'd12, 1'b1,1'b0, 5'd6,  1'b1, 5'd4,  1'b1, 2'd0,2'd1, 1'b0,1'b0},
    '{5'd1,  5'd2,  1'b1,1'b1, 5'd6,  5'd6,  5'd13, 1'b1,1'b0, 5'd6,  1'b1, 5'd6,  1'b1, 2'd2,2'd2, 1'b0,1'b0},
    '{5'd0,  5'd0,  1'b1,1'b1, 5'd0,  5'd0,  5'd0,  1'b1,1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 2'd0,2'd0, 1'b0,1'b0},
    '{5'd14, 5'd15, 1'b1,1'b1, 5'd7,  5'd7,  5'd16, 1'b1,1'b0, 5'd7,  1'b0, 5'd7,  1'b1, 2'd1,2'd1, 1'b0,1'b0},
    '{5'd9,  5'd5,  1'b1,1'b1, 5'd1,  5'd2,  5'd5,  1'b1,1'b1, 5'd20, 1'b1, 5'd21, 1'b1, 2'd0,2'd0, 1'b1,1'b1},
    '{5'd9,  5'd5,  1'b1,1'b0, 5'd1,  5'd2,  5'd5,  1'b1,1'b1, 5'd20, 1'b1, 5'd21, 1'b1, 2'd0,2'd0, 1'b0,1'b0},
    '{5'd17, 5'd18, 1'b1,1'b1, 5'd22, 5'd0,  5'd17, 1'b1,1'b0, 5'd23, 1'b1, 5'd24, 1'b1, 2'd0,2'd0, 1'b0,1'b1},
    '{5'd25, 5'd26, 1'b1,1'b1, 5'd26, 5'd3,  5'd27, 1'b1,1'b0, 5'd26, 1'b1, 5'd3,  1'b1, 2'd2,2'd1, 1'b0,1'b1},
    '{5'd17, 5'd18, 1'b1,1'b1, 5'd0,  5'd0,  5'd17, 1'b0,1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0,2'd0, 1'b0,1'b0},
    '{5'd8,  5'd0,  1'b1,1'b1, 5'd9,  5'd10, 5'd8,  1'b1,1'b1, 5'd9,  1'b1, 5'd10, 1'b1, 2'd2,2'd1, 1'b1,1'b1},
    '{5'd30, 5'd31, 1'b1,1'b1, 5'd11, 5'd12, 5'd29, 1'b1,1'b0, 5'd12, 1'b1, 5'd11, 1'b1, 2'd1,2'd2, 1'b0,1'b0},
    '{5'd2,  5'd3,  1'b1,1'b1, 5'd19, 5'd0,  5'd4,  1'b1,1'b0, 5'd0,  1'b1, 5'd19, 1'b0, 2'd0,2'd0, 1'b0,1'b0}
  };

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    #1;
    idRs1 = v.iA; idRs2 = v.iB; idRs1Used = v.uA; idRs2Used = v.uB;
    exRs1 = v.xA; exRs2 = v.xB; exRd = v.xRd; exRegWrite = v.xW; exMemRead = v.xMr;
    memRd = v.mRd; memRegWrite = v.mW; wbRd = v.wRd; wbRegWrite = v.wW;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    finished = 1'b1;
    $finish;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin : stim
    vec_t v;
    apply('0);
    // reset state: all-idle stage registers give no bypass and no stall (R1 R8)
    check("R1 reset fwdSelA", int'(fSelA), 0);
    check("R1 reset fwdSelB", int'(fSelB), 0);
    check("R8 reset holds", int'({fStall, fPc, fIfId, fBub, nStall, nPc, nIfId, nBub}), 0);
    repeat (2) @(posedge clk);
    rstN = 1'b1;

    // vector table: selects per R1 R2 R3 R4 R5, stalls per R7 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      apply(v);
      check($sformatf("R2/R3/R5 vec%0d fwd selA", i), int'(fSelA), int'(v.eA));
      check($sformatf("R4/R5 vec%0d fwd selB", i), int'(fSelB), int'(v.eB));
      check($sformatf("R7/R10/R11 vec%0d fwd stall", i), int'(fStall), int'(v.eSF));
      check($sformatf("R8 vec%0d fwd holds", i), int'({fPc, fIfId, fBub}), v.eSF ? 7 : 0);
      check($sformatf("R9 vec%0d nofwd sels", i), int'({nSelA, nSelB}), 0);
      check($sformatf("R7/R9/R11 vec%0d nofwd stall", i), int'(nStall), int'(v.eSN));
      check($sformatf("R8 vec%0d nofwd holds", i), int'({nPc, nIfId, nBub}), v.eSN ? 7 : 0);
    end

    // R6: load into each index, consumed by decode first source; only index 0 is silent
    for (int k = 0; k < 32; k++) begin
      v = '0;
      v.iA = 5'(k); v.uA = 1'b1; v.xRd = 5'(k); v.xW = 1'b1; v.xMr = 1'b1;
      v.xA = 5'(k); v.mRd = 5'(k); v.mW = 1'b1;
      apply(v);
      check($sformatf("R6 idx%0d fwd stall", k), int'(fStall), (k != 0) ? 1 : 0);
      check($sformatf("R6 idx%0d nofwd stall", k), int'(nStall), (k != 0) ? 1 : 0);
      check($sformatf("R6 idx%0d fwd selA", k), int'(fSelA), (k != 0) ? 2 : 0);
    end

    // R11: every index matches but neither decode source is read
    v = '0;
    v.iA = 5'd12; v.iB = 5'd12; v.xRd = 5'd12; v.xW = 1'b1; v.xMr = 1'b1;
    v.mRd = 5'd12; v.mW = 1'b1;
    apply(v);
    check("R11 unused sources fwd stall", int'(fStall), 0);
    check("R11 unused sources nofwd stall", int'(nStall), 0);

    // R10: second source matched by a memory-stage producer, no load
    v = '0;
    v.iB = 5'd21; v.uB = 1'b1; v.mRd = 5'd21; v.mW = 1'b1; v.xRd = 5'd21; v.xW = 1'b1;
    apply(v);
    check("R10 raw no load fwd stall", int'(fStall), 0);
    check("R9 raw via second source nofwd stall", int'(nStall), 1);

    finish_run();
  end

endmodule